// File: doc/BRIEF.md
# Aliased Set/Clear Enable Register

This block holds one small bank of enable bits (for example, clock-gate enables) behind an APB3 slave port with 32-bit data. The single storage register is reachable at three consecutive word addresses, and each address gives software a different way to write it. A write to the set view turns on every bit where the write data holds a one. A write to the clear view turns off every bit where the write data holds a one. The status view only reads. Because of this, software can change single enables without a read-modify-write sequence, and two agents that touch different bits cannot lose each other's updates.

The stored value drives the `gate_en` output at all times. The output changes on the same clock edge that completes the APB access phase.

Top module: `alias_en_reg`

## Requirements
- R1: After reset, `gate_en` is 0, and a read at any offset returns 0.
- R2: A completed write at byte offset 0x0 (the set view) ORs `pwdata[EN_W-1:0]` into the enables. Data bits that are 0 leave their enables unchanged.
- R3: A completed write at byte offset 0x4 (the clear view) clears every enable whose `pwdata` bit is 1. Data bits that are 0 leave their enables unchanged.
- R4: A write at byte offset 0x8 (the status view) leaves the enables unchanged.
- R5: A read at offset 0x0, 0x4 or 0x8 returns the current enables in `prdata[EN_W-1:0]`, with all higher bits 0. A read never changes the enables.
- R6: A read at any other offset returns 0. A write at any other offset leaves the enables unchanged. `pslverr` is always 0.
- R7: The enables update only on the clock edge where `psel`, `penable` and `pwrite` are all high. `pready` is always 1, so every access takes exactly two cycles and has no wait states.
- R8: `EN_W` sets the width of the enable field. Its default value is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| gate_en | output | EN_W | Current enable bits |

## Verification
The bench targets four kinds of error:

- **Mixed data patterns.** Writes to the set and clear views carry data that mixes ones and zeros, so the bench catches a design that copies the data instead of ORing it in or masking it out.
- **Write attempts that must do nothing.** The bench writes to the status view and to unmapped offsets. A decoder that ignores address bits, or lets the status view through, would show a changed `gate_en`.
- **Setup-phase writes.** Some writes are held in the setup phase with `penable` low. A design that updates there would move `gate_en` one cycle early.
- **Read-back of the upper bits.** Reads on every alias and on unmapped offsets check that the upper bits are zero and that reads have no side effects.

// File: rtl/alias_en_pkg.sv
package alias_en_pkg;
  typedef enum logic [1:0] {
    VIEW_SET  = 2'd0,
    VIEW_CLR  = 2'd1,
    VIEW_STAT = 2'd2,
    VIEW_NONE = 2'd3
  } view_e;

  localparam int unsigned DATA_W = 32;
endpackage

// File: rtl/alias_en_decode.sv
module alias_en_decode #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output alias_en_pkg::view_e view
);
  import alias_en_pkg::*;

  function automatic view_e decode_view(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_W'(0): decode_view = VIEW_SET;
      ADDR_W'(4): decode_view = VIEW_CLR;
      ADDR_W'(8): decode_view = VIEW_STAT;
      default:    decode_view = VIEW_NONE;
    endcase
  endfunction

  assign view = decode_view(addr);
endmodule

// File: rtl/alias_en_store.sv
module alias_en_store #(
  parameter int unsigned EN_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  alias_en_pkg::view_e view,
  input  logic [EN_W-1:0] wmask,
  output logic [EN_W-1:0] en_q
);
  import alias_en_pkg::*;

  function automatic logic [EN_W-1:0] next_en(
    input logic [EN_W-1:0] cur,
    input view_e           v,
    input logic [EN_W-1:0] m
  );
    case (v)
      VIEW_SET: next_en = cur | m;
      VIEW_CLR: next_en = cur & ~m;
      default:  next_en = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_fire) en_q <= next_en(en_q, view, wmask);
  end
endmodule

// File: rtl/alias_en_reg.sv
module alias_en_reg #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned EN_W   = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [EN_W-1:0]   gate_en
);
  import alias_en_pkg::*;

  localparam int unsigned PAD_W = DATA_W - EN_W;

  view_e           view;
  logic            wr_fire;
  logic            rd_hit;
  logic [EN_W-1:0] en_q;

  alias_en_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (paddr),
    .view (view)
  );

  assign wr_fire = psel & penable & pwrite;
  assign rd_hit  = (view != VIEW_NONE);

  alias_en_store #(.EN_W(EN_W)) u_store (
    .clk     (pclk),
    .rst_n   (presetn),
    .wr_fire (wr_fire),
    .view    (view),
    .wmask   (pwdata[EN_W-1:0]),
    .en_q    (en_q)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign prdata = rd_hit ? {{PAD_W{1'b0}}, en_q} : '0;
    end else begin : g_full
      assign prdata = rd_hit ? en_q[DATA_W-1:0] : '0;
    end
  endgenerate

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign gate_en = en_q;
endmodule

// File: rtl/alias_en_reg_chk.sv
module alias_en_reg_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned EN_W   = 4
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [EN_W-1:0]   gate_en
);
  logic fire;
  assign fire = psel & penable & pwrite;

  a_r7_no_change_without_write: assert property (@(posedge pclk) disable iff (!presetn)
    !fire |=> $stable(gate_en));
  a_r2_set_bits: assert property (@(posedge pclk) disable iff (!presetn)
    (fire && paddr == ADDR_W'(0)) |=> ((gate_en & $past(pwdata[EN_W-1:0])) == $past(pwdata[EN_W-1:0])));
  a_r3_clear_bits: assert property (@(posedge pclk) disable iff (!presetn)
    (fire && paddr == ADDR_W'(4)) |=> ((gate_en & $past(pwdata[EN_W-1:0])) == '0));
  a_r4_status_write_ignored: assert property (@(posedge pclk) disable iff (!presetn)
    (fire && paddr == ADDR_W'(8)) |=> $stable(gate_en));
  a_r6_no_error: assert property (@(posedge pclk) disable iff (!presetn)
    !pslverr && pready);
  a_r5_upper_zero: assert property (@(posedge pclk) disable iff (!presetn)
    (prdata >> EN_W) == '0);
endmodule

bind alias_en_reg alias_en_reg_chk #(.ADDR_W(ADDR_W), .EN_W(EN_W)) u_chk (.*);

// File: tb/tb_alias_en_reg.sv
module tb_alias_en_reg;
  localparam int AW = 12;
  localparam int EW = 4;

  logic          pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [EW-1:0] gate_en;

  int n_chk = 0, n_fail = 0;
  logic [EW-1:0] model = '0;
  logic model_on = 0;
  bit done = 0;

  alias_en_reg #(.ADDR_W(AW), .EN_W(EW)) dut (.*);

  always #2.5 pclk = ~pclk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the behavioural model
  always @(negedge pclk) if (model_on) check("R7 cycle", {28'd0, gate_en}, {28'd0, model});

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge pclk); #1;
    penable = 1;
    @(posedge pclk);
    if (a == 0) model = model | d[EW-1:0];
    else if (a == 4) model = model & ~d[EW-1:0];
    #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(posedge pclk); #1;
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge pclk); #1;
    penable = 1; #1;
    check(req, prdata, exp);
    check({req, " pslverr"}, {31'd0, pslverr}, 32'd0);
    @(posedge pclk); #1;
    psel = 0; penable = 0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge pclk);
    #1;
    check("R1 reset gate_en", {28'd0, gate_en}, 0);
    presetn = 1;
    model_on = 1;
    rd(0, 0, "R1 reset rd0");
    rd(8, 0, "R1 reset rd8");
    check("R8 width", $bits(gate_en), 4);
    wr(0, 32'hFFFF_FFF5);              // R2 set 0101
    rd(8, 32'h5, "R2 set 0101");
    wr(0, 32'h2);                      // R2 mixed
    rd(4, 32'h7, "R2 or-in");
    wr(4, 32'h5);                      // R3 clear
    rd(0, 32'h2, "R3 clear");
    wr(4, 32'h0);
    rd(8, 32'h2, "R3 zero data no change");
    wr(8, 32'hF);                      // R4
    rd(8, 32'h2, "R4 status write ignored");
    wr(12, 32'hF); wr(32'h10, 32'hF); wr(32'h100, 32'hF); // R6
    rd(8, 32'h2, "R6 unmapped write ignored");
    rd(12, 32'h0, "R6 unmapped read");
    rd(32'h104, 32'h0, "R6 far read");
    // R7: setup phase only, no enable
    @(posedge pclk); #1;
    psel = 1; pwrite = 1; paddr = 0; pwdata = 32'h8; penable = 0;
    @(posedge pclk); #1;
    check("R7 no setup update", {28'd0, gate_en}, 32'h2);
    psel = 0; pwrite = 0;
    wr(0, 32'hC);
    rd(4, 32'hE, "R5 read alias clear view");
    rd(4, 32'hE, "R5 read no side effect");
    wr(4, 32'hF);
    rd(0, 32'h0, "R3 clear all");
    model_on = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule